// File: doc/BRIEF.md
# Special Register Write Path

This block carries out the write half of a move-to-special-register operation in a small 32-bit processor core. For each request it takes a target selector, a 32-bit source value, the index of the general register that supplied the value, the current privilege level and the result of the instruction's condition test. It then updates at most one of the core's special registers. These registers are the five arithmetic status flags, the main and process stack pointers, the interrupt mask bit, the fault mask bit, the priority floor used to block lower-urgency interrupts, and the two-bit mode control register. Every one of them is driven straight onto an output port for the rest of the core to read.

The block checks the privilege level against the target and keeps each register to its defined width. It applies the conditional rule for the priority-raise alias. It rejects source registers that may not be used as an operand and reports them with a one-cycle pulse. The exception number and execution-state fields are fixed by other logic, and this path never changes them.

Top module: `spr_write_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every register clears to zero except the main stack pointer, which takes the value on `main_sp_init`. `bad_src` is low after reset.
- R2: A privileged write to selector 8 loads the main stack pointer, and a privileged write to selector 9 loads the process stack pointer. In both cases bits 1:0 of the stored value are zero.
- R3: Privileged writes store only the low bits of the source. Selector 16 (interrupt mask) and selector 19 (fault mask) keep bit 0, selector 17 (priority floor) keeps bits 7:0, and selector 20 (mode control) keeps bits 1:0.
- R4: Selectors 0, 1, 2 and 3 are the status views that contain the arithmetic flags. A write to any of them sets `flags_q[4:0]` to source bits 31:27, in the order N, Z, C, V, Q, with N in bit 4. Selectors 5, 6 and 7 are the status views without the flags, and a write to them changes nothing.
- R5: When `priv` is low, only the flag update of R4 takes effect, and it is applied the same way through any of selectors 0 to 3. Writes to every other target are dropped.
- R6: Selector 18 is the priority-raise alias. It loads source bits 7:0 into the priority floor only when that value is non-zero and the current floor is either zero or numerically greater than the new value. In every other case the floor keeps its value.
- R7: A request whose `src_idx` is 13 or 15 writes nothing. `bad_src` is high for exactly the one cycle after such a request, whatever `cond_ok` is.
- R8: A request with `cond_ok` low changes no register.
- R9: A selector value outside 0-3, 5-9 and 16-20 changes no register.
- R10: A register changes only at the rising edge where `wr_valid` is high. With `wr_valid` low, no register changes, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| main_sp_init | input | 32 | Value loaded into the main stack pointer at reset |
| wr_valid | input | 1 | Request strobe, one per cycle |
| wr_sel | input | 8 | Target selector |
| wr_data | input | 32 | Source value |
| src_idx | input | 4 | Index of the general register supplying the value |
| priv | input | 1 | 1 = privileged, 0 = unprivileged |
| cond_ok | input | 1 | Condition test passed |
| bad_src | output | 1 | One-cycle pulse after a request with a forbidden source |
| flags_q | output | 5 | N, Z, C, V, Q flags (N in bit 4) |
| main_sp_q | output | 32 | Main stack pointer |
| proc_sp_q | output | 32 | Process stack pointer |
| irq_mask_q | output | 1 | Interrupt mask bit |
| prio_floor_q | output | 8 | Priority floor |
| fault_mask_q | output | 1 | Fault mask bit |
| mode_ctrl_q | output | 2 | Mode control bits |

## Verification
All-ones source values are used for the stack pointers and the narrow registers, so that any stored bit above the kept width or in the forced-zero positions shows up at once. The priority-raise alias is tried with a lower value, a higher value, a zero value and a non-zero value against a cleared floor; these cases separate the lower-than test, the zero test and the current-is-zero path. The same writes are repeated at the unprivileged level, with the condition failed, and with source indices 13 and 15. This shows that each gate drops the write on its own while the flag path and the `bad_src` pulse keep their separate rules.

// File: rtl/spr_pkg.sv
// Shared definitions for the special register write path.
// Assumes an 8-bit selector; the code values are fixed by the requirement list.
package spr_pkg;

    localparam int SEL_W  = 8;
    localparam int FLAG_W = 5;

    typedef enum logic [SEL_W-1:0] {
        SEL_APP_STAT   = 8'd0,
        SEL_INTAPP     = 8'd1,
        SEL_EXEAPP     = 8'd2,
        SEL_ALLSTAT    = 8'd3,
        SEL_INTNUM     = 8'd5,
        SEL_EXESTAT    = 8'd6,
        SEL_INTEXE     = 8'd7,
        SEL_MAIN_SP    = 8'd8,
        SEL_PROC_SP    = 8'd9,
        SEL_IRQ_MASK   = 8'd16,
        SEL_PRIO_FLOOR = 8'd17,
        SEL_PRIO_RAISE = 8'd18,
        SEL_FAULT_MASK = 8'd19,
        SEL_MODE_CTRL  = 8'd20
    } spr_sel_e;

    // One enable for each register, or for each way of writing it.
    typedef struct packed {
        logic flags;
        logic main_sp;
        logic proc_sp;
        logic irq_mask;
        logic prio_set;
        logic prio_raise;
        logic fault_mask;
        logic mode_ctrl;
    } spr_wen_t;

endpackage

// File: rtl/spr_src_check.sv
// Flags a source register index that may not feed a special register write.
// Assumes the stack pointer and program counter indices are given as parameters.
module spr_src_check #(
    parameter int IDX_W  = 4,
    parameter int SP_IDX = 13,
    parameter int PC_IDX = 15
) (
    input  logic [IDX_W-1:0] idx,
    output logic             forbidden
);

    localparam logic [IDX_W-1:0] SP_V = IDX_W'(SP_IDX);
    localparam logic [IDX_W-1:0] PC_V = IDX_W'(PC_IDX);

    // Compare the index against the two reserved registers.
    always_comb begin
        forbidden = (idx == SP_V) || (idx == PC_V);
    end

endmodule

// File: rtl/spr_req_decode.sv
// Turns a gated request into one-hot register enables.
// Assumes go already includes valid, condition pass and source legality.
// At the unprivileged level only the flag enable can be raised.
module spr_req_decode
    import spr_pkg::*;
(
    input  logic             go,
    input  logic             priv,
    input  logic [SEL_W-1:0] sel,
    output spr_wen_t         wen
);

    // Decode the selector, then apply the privilege rule.
    always_comb begin
        wen = '0;
        if (go) begin
            case (sel)
                SEL_APP_STAT, SEL_INTAPP, SEL_EXEAPP, SEL_ALLSTAT:
                    wen.flags = 1'b1;
                SEL_MAIN_SP:    wen.main_sp    = priv;
                SEL_PROC_SP:    wen.proc_sp    = priv;
                SEL_IRQ_MASK:   wen.irq_mask   = priv;
                SEL_PRIO_FLOOR: wen.prio_set   = priv;
                SEL_PRIO_RAISE: wen.prio_raise = priv;
                SEL_FAULT_MASK: wen.fault_mask = priv;
                SEL_MODE_CTRL:  wen.mode_ctrl  = priv;
                default:        wen = '0;
            endcase
        end
    end

endmodule

// File: rtl/spr_prio_gate.sv
// Decides whether a priority-raise write may replace the current floor.
// Assumes a lower non-zero number means stronger masking and zero means off.
module spr_prio_gate #(
    parameter int PRIO_W = 8
) (
    input  logic [PRIO_W-1:0] cur,
    input  logic [PRIO_W-1:0] nxt,
    output logic              take
);

    // The new value is taken only if it masks more than the current one.
    always_comb begin
        take = (nxt != '0) && ((cur == '0) || (nxt < cur));
    end

endmodule

// File: rtl/spr_write_unit.sv
// Write path for a move-to-special-register operation.
// Holds the flag bits, both stack pointers, the mask bits, the priority
// floor and the mode control bits, and drives each onto a port.
// Assumes one request per cycle and a synchronous active-low reset.
module spr_write_unit
    import spr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4,
    parameter int PRIO_W = 8,
    parameter int CTRL_W = 2,
    parameter int ALIGN  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] main_sp_init,
    input  logic              wr_valid,
    input  logic [7:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  src_idx,
    input  logic              priv,
    input  logic              cond_ok,
    output logic              bad_src,
    output logic [4:0]        flags_q,
    output logic [DATA_W-1:0] main_sp_q,
    output logic [DATA_W-1:0] proc_sp_q,
    output logic              irq_mask_q,
    output logic [PRIO_W-1:0] prio_floor_q,
    output logic              fault_mask_q,
    output logic [CTRL_W-1:0] mode_ctrl_q
);

    localparam logic [DATA_W-1:0] SP_MASK = ~(DATA_W'((1 << ALIGN) - 1));

    logic     forbidden;
    logic     go;
    logic     raise_ok;
    spr_wen_t wen;

    spr_src_check #(.IDX_W(IDX_W)) u_src (
        .idx       (src_idx),
        .forbidden (forbidden)
    );

    // A request proceeds only when it is valid, the condition passed and the source is legal.
    always_comb begin
        go = wr_valid && cond_ok && !forbidden;
    end

    spr_req_decode u_dec (
        .go   (go),
        .priv (priv),
        .sel  (wr_sel),
        .wen  (wen)
    );

    spr_prio_gate #(.PRIO_W(PRIO_W)) u_gate (
        .cur  (prio_floor_q),
        .nxt  (wr_data[PRIO_W-1:0]),
        .take (raise_ok)
    );

    // Register the illegal-source pulse for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) bad_src <= 1'b0;
        else        bad_src <= wr_valid && forbidden;
    end

    // Arithmetic flags, loaded from the top source bits.
    always_ff @(posedge clk) begin
        if (!rst_n)         flags_q <= '0;
        else if (wen.flags) flags_q <= wr_data[DATA_W-1 -: FLAG_W];
    end

    // Main stack pointer with forced alignment; reset loads the init input.
    always_ff @(posedge clk) begin
        if (!rst_n)           main_sp_q <= main_sp_init;
        else if (wen.main_sp) main_sp_q <= wr_data & SP_MASK;
    end

    // Process stack pointer with forced alignment.
    always_ff @(posedge clk) begin
        if (!rst_n)           proc_sp_q <= '0;
        else if (wen.proc_sp) proc_sp_q <= wr_data & SP_MASK;
    end

    // Single-bit interrupt mask and fault mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_mask_q   <= 1'b0;
            fault_mask_q <= 1'b0;
        end else begin
            if (wen.irq_mask)   irq_mask_q   <= wr_data[0];
            if (wen.fault_mask) fault_mask_q <= wr_data[0];
        end
    end

    // Priority floor: direct load, or a raise gated by the compare.
    always_ff @(posedge clk) begin
        if (!rst_n)                          prio_floor_q <= '0;
        else if (wen.prio_set)               prio_floor_q <= wr_data[PRIO_W-1:0];
        else if (wen.prio_raise && raise_ok) prio_floor_q <= wr_data[PRIO_W-1:0];
    end

    // Mode control bits.
    always_ff @(posedge clk) begin
        if (!rst_n)             mode_ctrl_q <= '0;
        else if (wen.mode_ctrl) mode_ctrl_q <= wr_data[CTRL_W-1:0];
    end

endmodule

// File: rtl/spr_write_unit_chk.sv
// Temporal checks on the special register write path, bound to the top.
module spr_write_unit_chk #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4,
    parameter int PRIO_W = 8,
    parameter int CTRL_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic [7:0]        wr_sel,
    input logic [IDX_W-1:0]  src_idx,
    input logic              priv,
    input logic              cond_ok,
    input logic              bad_src,
    input logic [4:0]        flags_q,
    input logic [DATA_W-1:0] main_sp_q,
    input logic [DATA_W-1:0] proc_sp_q,
    input logic              irq_mask_q,
    input logic [PRIO_W-1:0] prio_floor_q,
    input logic              fault_mask_q,
    input logic [CTRL_W-1:0] mode_ctrl_q
);

    logic bad_idx;
    assign bad_idx = (src_idx == IDX_W'(13)) || (src_idx == IDX_W'(15));

    // R7
    bad_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && bad_idx) |=> bad_src);

    // R7
    bad_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && bad_idx) |=> !bad_src);

    // R7
    bad_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && bad_idx) |=> ($stable(flags_q) && $stable(main_sp_q) &&
        $stable(proc_sp_q) && $stable(prio_floor_q) && $stable(mode_ctrl_q)));

    // R8
    cond_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !cond_ok) |=> ($stable(flags_q) && $stable(main_sp_q) &&
        $stable(proc_sp_q) && $stable(irq_mask_q) && $stable(fault_mask_q) &&
        $stable(prio_floor_q) && $stable(mode_ctrl_q)));

    // R5
    unpriv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !priv) |=> ($stable(main_sp_q) && $stable(proc_sp_q) &&
        $stable(irq_mask_q) && $stable(fault_mask_q) &&
        $stable(prio_floor_q) && $stable(mode_ctrl_q)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> ($stable(flags_q) && $stable(main_sp_q) &&
        $stable(proc_sp_q) && $stable(irq_mask_q) && $stable(fault_mask_q) &&
        $stable(prio_floor_q) && $stable(mode_ctrl_q)));

    // R6
    raise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_sel == 8'd18 && prio_floor_q != '0) |=>
        (prio_floor_q != '0 && prio_floor_q <= $past(prio_floor_q)));

    // R2
    sp_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && priv && cond_ok && !bad_idx && wr_sel == 8'd9) |=>
        (proc_sp_q[1:0] == 2'b00));

endmodule

bind spr_write_unit spr_write_unit_chk #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .PRIO_W(PRIO_W), .CTRL_W(CTRL_W)
) u_chk (.*);

// File: tb/sim_spr_write_unit.sv
// Self-checking bench: a vector table walked once, then directed cases.
module sim_spr_write_unit;

    localparam logic [31:0] SP_INIT = 32'h2000_0FFF;

    typedef struct packed {
        logic        pv;
        logic [7:0]  sel;
        logic [31:0] data;
        logic [3:0]  src;
        logic        cnd;
        logic [2:0]  rd;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    // rd: 0 flags, 1 main sp, 2 proc sp, 3 irq mask, 4 floor, 5 fault mask, 6 mode
    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 8'd8,  32'h3000_1237, 4'd1, 1'b1, 3'd1, 32'h3000_1234, 4'd2}, // R2
        '{1'b1, 8'd9,  32'hFFFF_FFFF, 4'd2, 1'b1, 3'd2, 32'hFFFF_FFFC, 4'd2}, // R2
        '{1'b1, 8'd16, 32'hFFFF_FFFF, 4'd0, 1'b1, 3'd3, 32'h1,         4'd3}, // R3
        '{1'b1, 8'd19, 32'h0000_0006, 4'd0, 1'b1, 3'd5, 32'h0,         4'd3}, // R3
        '{1'b1, 8'd20, 32'hFFFF_FFFF, 4'd0, 1'b1, 3'd6, 32'h3,         4'd3}, // R3
        '{1'b1, 8'd17, 32'h0000_1280, 4'd0, 1'b1, 3'd4, 32'h80,        4'd3}, // R3
        '{1'b1, 8'd18, 32'h0000_0040, 4'd0, 1'b1, 3'd4, 32'h40,        4'd6}, // R6 lower
        '{1'b1, 8'd18, 32'h0000_0060, 4'd0, 1'b1, 3'd4, 32'h40,        4'd6}, // R6 higher
        '{1'b1, 8'd18, 32'h0000_0000, 4'd0, 1'b1, 3'd4, 32'h40,        4'd6}, // R6 zero
        '{1'b1, 8'd17, 32'h0000_0000, 4'd0, 1'b1, 3'd4, 32'h0,         4'd3}, // R3
        '{1'b1, 8'd18, 32'h0000_00C0, 4'd0, 1'b1, 3'd4, 32'hC0,        4'd6}, // R6 from zero
        '{1'b1, 8'd0,  32'hA800_0000, 4'd0, 1'b1, 3'd0, 32'h15,        4'd4}, // R4
        '{1'b1, 8'd3,  32'h5000_0000, 4'd0, 1'b1, 3'd0, 32'h0A,        4'd4}, // R4
        '{1'b1, 8'd5,  32'hF800_0000, 4'd0, 1'b1, 3'd0, 32'h0A,        4'd4}, // R4 no flags
        '{1'b0, 8'd0,  32'hF800_01FF, 4'd0, 1'b1, 3'd0, 32'h1F,        4'd5}, // R5 flags ok
        '{1'b0, 8'd8,  32'h0000_0000, 4'd0, 1'b1, 3'd1, 32'h3000_1234, 4'd5}, // R5
        '{1'b0, 8'd20, 32'h0000_0000, 4'd0, 1'b1, 3'd6, 32'h3,         4'd5}, // R5
        '{1'b0, 8'd18, 32'h0000_0001, 4'd0, 1'b1, 3'd4, 32'hC0,        4'd5}, // R5
        '{1'b1, 8'd4,  32'h0000_0000, 4'd0, 1'b1, 3'd0, 32'h1F,        4'd9}, // R9
        '{1'b1, 8'd8,  32'h0000_0000, 4'd0, 1'b0, 3'd1, 32'h3000_1234, 4'd8}, // R8
        '{1'b1, 8'd8,  32'h0000_0000, 4'd13,1'b1, 3'd1, 32'h3000_1234, 4'd7}, // R7
        '{1'b1, 8'd9,  32'h0000_0000, 4'd15,1'b1, 3'd2, 32'hFFFF_FFFC, 4'd7}, // R7
        '{1'b0, 8'd1,  32'h0000_0000, 4'd0, 1'b1, 3'd0, 32'h0,         4'd4}  // R4 unpriv view
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  src_idx = '0;
    logic        priv = 1'b0;
    logic        cond_ok = 1'b0;
    logic        bad_src;
    logic [4:0]  flags_q;
    logic [31:0] main_sp_q;
    logic [31:0] proc_sp_q;
    logic        irq_mask_q;
    logic [7:0]  prio_floor_q;
    logic        fault_mask_q;
    logic [1:0]  mode_ctrl_q;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    spr_write_unit u0 (
        .clk(clk), .rst_n(rst_n), .main_sp_init(SP_INIT),
        .wr_valid(wr_valid), .wr_sel(wr_sel), .wr_data(wr_data),
        .src_idx(src_idx), .priv(priv), .cond_ok(cond_ok),
        .bad_src(bad_src), .flags_q(flags_q), .main_sp_q(main_sp_q),
        .proc_sp_q(proc_sp_q), .irq_mask_q(irq_mask_q),
        .prio_floor_q(prio_floor_q), .fault_mask_q(fault_mask_q),
        .mode_ctrl_q(mode_ctrl_q)
    );

    function automatic logic [31:0] readback(input logic [2:0] rd);
        case (rd)
            3'd0:    return {27'd0, flags_q};
            3'd1:    return main_sp_q;
            3'd2:    return proc_sp_q;
            3'd3:    return {31'd0, irq_mask_q};
            3'd4:    return {24'd0, prio_floor_q};
            3'd5:    return {31'd0, fault_mask_q};
            default: return {30'd0, mode_ctrl_q};
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One request in one cycle; returns at the next falling edge.
    task automatic do_write(input logic pv, input logic [7:0] sel, input logic [31:0] d,
                            input logic [3:0] src, input logic cnd);
        @(negedge clk);
        wr_valid = 1'b1; priv = pv; wr_sel = sel; wr_data = d;
        src_idx = src; cond_ok = cnd;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 flags", {27'd0, flags_q}, 32'h0);
        check("R1 main_sp", main_sp_q, SP_INIT);
        check("R1 proc_sp", proc_sp_q, 32'h0);
        check("R1 floor", {24'd0, prio_floor_q}, 32'h0);
        check("R1 bad_src", {31'd0, bad_src}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            do_write(VEC[i].pv, VEC[i].sel, VEC[i].data, VEC[i].src, VEC[i].cnd);
            check($sformatf("R%0d row %0d", VEC[i].req, i), readback(VEC[i].rd), VEC[i].exp);
        end

        // R7: pulse timing and level for a forbidden source with condition failed
        do_write(1'b1, 8'd9, 32'h0, 4'd13, 1'b0);
        check("R7 pulse high", {31'd0, bad_src}, 32'h1);
        @(negedge clk);
        check("R7 pulse ends", {31'd0, bad_src}, 32'h0);

        // R10: no strobe, no change; the write shows only after the edge
        @(negedge clk);
        wr_valid = 1'b0; priv = 1'b1; wr_sel = 8'd9; wr_data = 32'h1234_5678;
        src_idx = 4'd0; cond_ok = 1'b1;
        @(negedge clk);
        check("R10 idle", proc_sp_q, 32'hFFFF_FFFC);
        wr_valid = 1'b1;
        #1;
        check("R10 before edge", proc_sp_q, 32'hFFFF_FFFC);
        @(negedge clk);
        wr_valid = 1'b0;
        check("R10 after edge", proc_sp_q, 32'h1234_5678);

        // R1: reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 re-reset main_sp", main_sp_q, SP_INIT);
        check("R1 re-reset proc_sp", proc_sp_q, 32'h0);
        check("R1 re-reset mode", {30'd0, mode_ctrl_q}, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule